// File: doc/BRIEF.md
# Shift-Rotate Unit with Carry

This block is a purely combinational datapath stage that shifts or rotates an 8-bit or 16-bit operand in one pass. It covers a left shift (logical and arithmetic left are the same operation), a logical right shift, an arithmetic right shift, plain rotates in both directions, and rotates in both directions that pass through the carry bit. The operand, the incoming carry, an opcode, a size bit and a count come in. The shifted value, the new carry, an overflow bit and three flag write strobes go out. The surrounding execution stage uses the strobes to decide which flags it updates.

The count is either the constant one or a count value supplied with the operation. Only the low five bits of that count value are used. The whole count is handled in a single evaluation, so an enclosing pipeline sees a fixed combinational delay and no iteration.

Top module: `shrot_unit`

## Requirements
- R1: `op_i` encoding: 0 shift left, 1 logical shift right, 2 arithmetic shift right, 3 rotate left, 4 rotate right, 5 rotate left through carry, 6 rotate right through carry, 7 no operation. With `cnt_sel_i`=0 the count is 1 whatever `cnt_i` holds. With `cnt_sel_i`=1 the count is `cnt_i[4:0]`, and bits 7:5 are ignored.
- R2: Shift left fills the vacated low bits with zeros. Carry out is the last bit pushed past the top, and it is 0 once the count exceeds the operand width.
- R3: Logical shift right fills the vacated high bits with zeros. Carry out is operand bit count-1, and it is 0 once the count exceeds the width.
- R4: Arithmetic shift right refills the high bits with the original top bit. For counts at or above the width, every result bit and the carry equal that top bit.
- R5: Rotate left moves each bit leaving the top into bit 0, and rotate right moves each bit leaving bit 0 into the top. Carry out is the last bit that wrapped. A count that is a multiple of the width leaves the value unchanged but still writes carry.
- R6: The through-carry rotates act on a ring of width+1 bits with carry above the operand. The count is taken modulo width+1, so 1234 rotated right by 4 through a clear carry gives 8123 with carry 0.
- R7: `size_i`=0 selects byte mode: only `opnd_i[7:0]` is used, and `result_o[15:8]` is 0. `size_i`=1 selects word mode.
- R8: An effective count of zero returns the sized operand unchanged, with `carry_o`=`carry_i`, all write strobes low and `ovf_o`=0.
- R9: For a count of one on a left operation (codes 0, 3, 5), `ovf_o` is the new top result bit XOR `carry_o`.
- R10: For a count of one on a right operation (codes 1, 2, 4, 6), `ovf_o` is the XOR of the two top result bits.
- R11: For a nonzero count, `wr_carry_o` is 1. `wr_szp_o` is 1 for shifts only. `wr_ovf_o` is 1 only when the count is exactly one. `ovf_o` is 0 whenever `wr_ovf_o` is 0.
- R12: Opcode 7 returns the sized operand with `carry_o`=`carry_i` and no write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (see R1) |
| size_i | input | 1 | 0 byte, 1 word |
| cnt_sel_i | input | 1 | 0 count of one, 1 use `cnt_i` |
| cnt_i | input | 8 | Variable count value |
| opnd_i | input | 16 | Operand |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 16 | Shifted or rotated value, zero-extended in byte mode |
| carry_o | output | 1 | New carry (equals `carry_i` when not written) |
| ovf_o | output | 1 | Overflow, meaningful only with `wr_ovf_o` |
| wr_carry_o | output | 1 | Carry flag write strobe |
| wr_ovf_o | output | 1 | Overflow flag write strobe |
| wr_szp_o | output | 1 | Sign, zero and parity write strobe |

## Verification
The bench aims at the count edges where shifters usually break:

- **Counts equal to or just past the width.** A left shift by exactly the operand width must still deliver bit 0 as carry. A design that clamps early would return 0.
- **Through-carry rotates by width+1.** The value and carry must come back unchanged. A design that reduces modulo the width would scramble them.
- **Counts of zero.** The case is driven both directly and through a count whose ignored upper bits are set. A design that decodes those bits, or that strobes flags on an empty count, would corrupt the caller's flags.
- **Overflow at a count of one.** It is checked for left and right directions separately, and it is checked to be suppressed at counts such as 17 that act like a single-step rotate.
- **Byte mode.** A design that leaks operand bits 15:8 into the result fails here.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
   typedef enum logic [2:0] {
      OP_SHL = 3'd0,
      OP_SHR = 3'd1,
      OP_SAR = 3'd2,
      OP_ROL = 3'd3,
      OP_ROR = 3'd4,
      OP_RCL = 3'd5,
      OP_RCR = 3'd6,
      OP_NOP = 3'd7
   } shop_e;
endpackage

// File: rtl/shrot_amount.sv
module shrot_amount #(
   parameter int CNT_W    = 8,
   parameter int CNT_USED = 5
) (
   input  logic                cnt_sel,
   input  logic [CNT_W-1:0]    cnt,
   output logic [CNT_USED-1:0] n,
   output logic                n_zero,
   output logic                n_one
);
   logic unused_cnt_hi;

   generate
      if (CNT_W > CNT_USED) begin : g_hi
         assign unused_cnt_hi = ^cnt[CNT_W-1:CNT_USED];
      end else begin : g_nohi
         assign unused_cnt_hi = 1'b0;
      end
   endgenerate

   always_comb begin
      if (cnt_sel) n = cnt[CNT_USED-1:0];
      else         n = CNT_USED'(1);
      n_zero = (n == '0);
      n_one  = (n == CNT_USED'(1));
   end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
   import shrot_pkg::*;
#(
   parameter int W  = 16,
   parameter int NW = 5
) (
   input  shop_e         op,
   input  logic [NW-1:0] n,
   input  logic [W-1:0]  opnd,
   input  logic          cin,
   output logic [W-1:0]  res,
   output logic          cout
);
   logic [W:0]        ext_l, ext_r, ext_a, ring, rc_l, rc_r;
   logic signed [W:0] sx;
   logic [W-1:0]      rot_l, rot_r;
   int                nr, nrc;

   always_comb begin
      nr    = 32'(n) % W;
      nrc   = 32'(n) % (W + 1);
      ext_l = {1'b0, opnd} << n;
      ext_r = {opnd, 1'b0} >> n;
      sx    = {opnd, 1'b0};
      ext_a = sx >>> n;
      rot_l = (opnd << nr) | (opnd >> (W - nr));
      rot_r = (opnd >> nr) | (opnd << (W - nr));
      ring  = {cin, opnd};
      rc_l  = (ring << nrc) | (ring >> (W + 1 - nrc));
      rc_r  = (ring >> nrc) | (ring << (W + 1 - nrc));
      res   = opnd;
      cout  = cin;
      if (n != '0) begin
         unique case (op)
            OP_SHL: begin res = ext_l[W-1:0]; cout = ext_l[W]; end
            OP_SHR: begin res = ext_r[W:1];   cout = ext_r[0]; end
            OP_SAR: begin res = ext_a[W:1];   cout = ext_a[0]; end
            OP_ROL: begin res = rot_l;        cout = rot_l[0]; end
            OP_ROR: begin res = rot_r;        cout = rot_r[W-1]; end
            OP_RCL: begin res = rc_l[W-1:0];  cout = rc_l[W]; end
            OP_RCR: begin res = rc_r[W-1:0];  cout = rc_r[W]; end
            default: begin res = opnd;        cout = cin; end
         endcase
      end
   end

   always_comb begin
      if (op == OP_SHL && n != '0)
         assert_shl_zero_fill_R2: assert (res[0] == 1'b0);
      if (op == OP_SAR && n != '0)
         assert_sar_sign_keep_R4: assert (res[W-1] == opnd[W-1]);
      if ((op == OP_ROL || op == OP_ROR) && n != '0)
         assert_rot_ones_kept_R5: assert ($countones(res) == $countones(opnd));
      if (op == OP_RCL || op == OP_RCR)
         assert_ring_ones_kept_R6: assert ($countones({cout, res}) == $countones({cin, opnd}));
      if (n == '0)
         assert_zero_count_pass_R8: assert (res == opnd && cout == cin);
   end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
   import shrot_pkg::*;
(
   input  shop_e op,
   input  logic  n_zero,
   input  logic  n_one,
   input  logic  top_bit,
   input  logic  next_bit,
   input  logic  lane_c,
   input  logic  cin,
   output logic  carry_o,
   output logic  ovf_o,
   output logic  wr_c,
   output logic  wr_o,
   output logic  wr_szp
);
   logic active, is_shift, is_left;

   always_comb begin
      is_shift = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
      is_left  = (op == OP_SHL) || (op == OP_ROL) || (op == OP_RCL);
      active   = !n_zero && (op != OP_NOP);
      wr_c     = active;
      wr_szp   = active && is_shift;
      wr_o     = active && n_one;
      carry_o  = active ? lane_c : cin;
      if (!wr_o)        ovf_o = 1'b0;
      else if (is_left) ovf_o = top_bit ^ lane_c;
      else              ovf_o = top_bit ^ next_bit;
   end

   always_comb begin
      if (wr_o)
         assert_ovf_needs_carry_R11: assert (wr_c);
      if (wr_szp)
         assert_szp_needs_carry_R11: assert (wr_c);
      if (!wr_c)
         assert_carry_held_R8: assert (carry_o == cin && !ovf_o);
   end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter int CNT_USED = 5
) (
   input  logic [2:0]        op_i,
   input  logic              size_i,
   input  logic              cnt_sel_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              ovf_o,
   output logic              wr_carry_o,
   output logic              wr_ovf_o,
   output logic              wr_szp_o
);
   localparam int NARROW_W = DATA_W / 2;
   localparam int N_LANES  = 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("shrot_unit: DATA_W must be even and at least 4");
      end
      if (CNT_USED < 1 || CNT_USED > CNT_W) begin : g_bad_count
         $error("shrot_unit: CNT_USED must lie in 1..CNT_W");
      end
   endgenerate

   shop_e                op;
   logic [CNT_USED-1:0]  n;
   logic                 n_zero, n_one;
   logic [DATA_W-1:0]    lane_res [N_LANES];
   logic                 lane_c   [N_LANES];
   logic                 top_bit, next_bit, sel_c;

   assign op = shop_e'(op_i);

   shrot_amount #(.CNT_W(CNT_W), .CNT_USED(CNT_USED)) u_amount (
      .cnt_sel (cnt_sel_i),
      .cnt     (cnt_i),
      .n       (n),
      .n_zero  (n_zero),
      .n_one   (n_one)
   );

   generate
      for (genvar g = 0; g < N_LANES; g++) begin : g_lane
         localparam int LW = (g == 0) ? NARROW_W : DATA_W;
         logic [LW-1:0] r;
         logic          c;
         shrot_lane #(.W(LW), .NW(CNT_USED)) u_lane (
            .op   (op),
            .n    (n),
            .opnd (opnd_i[LW-1:0]),
            .cin  (carry_i),
            .res  (r),
            .cout (c)
         );
         assign lane_res[g] = DATA_W'(r);
         assign lane_c[g]   = c;
      end
   endgenerate

   always_comb begin
      result_o = size_i ? lane_res[1] : lane_res[0];
      sel_c    = size_i ? lane_c[1]   : lane_c[0];
      top_bit  = size_i ? result_o[DATA_W-1]   : result_o[NARROW_W-1];
      next_bit = size_i ? result_o[DATA_W-2]   : result_o[NARROW_W-2];
   end

   shrot_flags u_flags (
      .op       (op),
      .n_zero   (n_zero),
      .n_one    (n_one),
      .top_bit  (top_bit),
      .next_bit (next_bit),
      .lane_c   (sel_c),
      .cin      (carry_i),
      .carry_o  (carry_o),
      .ovf_o    (ovf_o),
      .wr_c     (wr_carry_o),
      .wr_o     (wr_ovf_o),
      .wr_szp   (wr_szp_o)
   );

   always_comb begin
      if (!size_i)
         assert_byte_upper_zero_R7: assert (result_o[DATA_W-1:NARROW_W] == '0);
   end
endmodule

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op;
   logic        size, csel, cin;
   logic [7:0]  cnt;
   logic [15:0] opnd;
   logic [15:0] res;
   logic        cout, ovf, wc, wo, ws;
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 1'b0;

   always #2 clk = ~clk;

   shrot_unit dut_i (
      .op_i(op), .size_i(size), .cnt_sel_i(csel), .cnt_i(cnt),
      .opnd_i(opnd), .carry_i(cin), .result_o(res), .carry_o(cout),
      .ovf_o(ovf), .wr_carry_o(wc), .wr_ovf_o(wo), .wr_szp_o(ws)
   );

   // behavioural model: one bit step per iteration
   task automatic model(output logic [15:0] e_res, output logic e_c, output logic e_o,
                        output logic e_wc, output logic e_wo, output logic e_ws);
      int          w = size ? 16 : 8;
      int          n = csel ? int'(cnt[4:0]) : 1;
      logic [16:0] v = size ? {1'b0, opnd} : {9'b0, opnd[7:0]};
      logic        c = cin;
      logic        t;
      e_res = v[15:0]; e_c = cin; e_o = 1'b0; e_wc = 1'b0; e_wo = 1'b0; e_ws = 1'b0;
      if (n == 0 || op == 3'd7) return;
      for (int i = 0; i < n; i++) begin
         case (op)
            3'd0: begin c = v[w-1]; v = v << 1; v[w] = 1'b0; end
            3'd1: begin c = v[0]; v = v >> 1; end
            3'd2: begin c = v[0]; t = v[w-1]; v = v >> 1; v[w-1] = t; end
            3'd3: begin c = v[w-1]; v = v << 1; v[w] = 1'b0; v[0] = c; end
            3'd4: begin c = v[0]; v = v >> 1; v[w-1] = c; end
            3'd5: begin t = v[w-1]; v = v << 1; v[w] = 1'b0; v[0] = c; c = t; end
            default: begin t = v[0]; v = v >> 1; v[w-1] = c; c = t; end
         endcase
      end
      e_res = v[15:0]; e_c = c; e_wc = 1'b1;
      e_ws = (op <= 3'd2);
      e_wo = (n == 1);
      if (n == 1) begin
         if (op == 3'd0 || op == 3'd3 || op == 3'd5) e_o = v[w-1] ^ c;
         else e_o = v[w-1] ^ v[w-2];
      end
   endtask

   task automatic chk_model(input string tag);
      logic [15:0] er; logic ec, eo, ewc, ewo, ews;
      model(er, ec, eo, ewc, ewo, ews);
      checks++;
      if ({res, cout, ovf, wc, wo, ws} !== {er, ec, eo, ewc, ewo, ews}) begin
         fails++;
         $display("FAIL %s op=%0d size=%0d sel=%0d cnt=%0d opnd=%h cin=%0d : actual res=%h c=%0d o=%0d wr=%0d%0d%0d expected res=%h c=%0d o=%0d wr=%0d%0d%0d",
                  tag, op, size, csel, cnt, opnd, cin, res, cout, ovf, wc, wo, ws,
                  er, ec, eo, ewc, ewo, ews);
      end
   endtask

   task automatic chk_lit(input string tag, input logic [15:0] er, input logic ec);
      checks++;
      if (res !== er || cout !== ec) begin
         fails++;
         $display("FAIL %s : actual res=%h c=%0d expected res=%h c=%0d", tag, res, cout, er, ec);
      end
   endtask

   task automatic apply(input logic [2:0] o, input logic s, input logic sl,
                        input logic [7:0] ct, input logic [15:0] d, input logic ci);
      @(negedge clk);
      op = o; size = s; csel = sl; cnt = ct; opnd = d; cin = ci;
      @(negedge clk);
   endtask

   initial begin
      op = 3'd0; size = 1'b0; csel = 1'b1; cnt = 8'd0; opnd = 16'd0; cin = 1'b0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_model("R8 idle zero state");
      chk_lit("R8 idle result", 16'h0000, 1'b0);

      apply(3'd2, 1'b1, 1'b1, 8'd2, 16'h091A, 1'b0);
      chk_lit("R4 sar 091A by 2", 16'h0246, 1'b1);           chk_model("R4");
      apply(3'd6, 1'b1, 1'b1, 8'd4, 16'h1234, 1'b0);
      chk_lit("R6 rcr 1234 by 4", 16'h8123, 1'b0);           chk_model("R6");
      apply(3'd1, 1'b0, 1'b1, 8'd4, 16'h12B8, 1'b0);
      chk_lit("R3 R7 byte shr by 4", 16'h000B, 1'b1);        chk_model("R3");
      apply(3'd0, 1'b0, 1'b1, 8'd8, 16'h0003, 1'b0);
      chk_lit("R2 shl byte by width", 16'h0000, 1'b1);       chk_model("R2");
      apply(3'd0, 1'b0, 1'b1, 8'd9, 16'h00FF, 1'b1);
      chk_lit("R2 shl byte past width", 16'h0000, 1'b0);     chk_model("R2");
      apply(3'd2, 1'b1, 1'b1, 8'd31, 16'h8000, 1'b0);
      chk_lit("R4 sar word by 31", 16'hFFFF, 1'b1);          chk_model("R4");
      apply(3'd3, 1'b1, 1'b0, 8'd9, 16'h8001, 1'b0);
      chk_lit("R5 R1 rol count one", 16'h0003, 1'b1);        chk_model("R9");
      apply(3'd4, 1'b1, 1'b0, 8'd0, 16'h0001, 1'b0);
      chk_lit("R5 ror count one", 16'h8000, 1'b1);           chk_model("R10");
      apply(3'd5, 1'b0, 1'b1, 8'd9, 16'h005A, 1'b1);
      chk_lit("R6 rcl byte by 9", 16'h005A, 1'b1);           chk_model("R6");
      apply(3'd3, 1'b1, 1'b1, 8'd16, 16'hC001, 1'b0);
      chk_lit("R5 rol by width", 16'hC001, 1'b1);            chk_model("R5");
      apply(3'd3, 1'b1, 1'b1, 8'd17, 16'h8001, 1'b0);
      chk_lit("R11 rol by 17", 16'h0003, 1'b1);              chk_model("R11");
      apply(3'd0, 1'b1, 1'b1, 8'hE0, 16'hABCD, 1'b1);
      chk_lit("R1 R8 upper count bits ignored", 16'hABCD, 1'b1); chk_model("R8");
      apply(3'd7, 1'b0, 1'b1, 8'd3, 16'hABCD, 1'b0);
      chk_lit("R12 opcode 7 no-op", 16'h00CD, 1'b0);         chk_model("R12");

      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         op   = 3'($urandom_range(0, 7));
         size = 1'($urandom);
         csel = ($urandom_range(0, 3) != 0);
         cnt  = 8'($urandom);
         opnd = 16'($urandom);
         cin  = 1'($urandom);
         @(negedge clk);
         chk_model((op <= 3'd2) ? "R2 R3 R4 R11 random shift" :
                   (op <= 3'd4) ? "R5 R9 R10 random rotate" :
                   (op <= 3'd6) ? "R6 random carry rotate" : "R12 random no-op");
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule